// File: doc/BRIEF.md
# Transmit Dominant Timeout Monitor

This block sits in the digital core of a CAN transceiver, between the protocol controller's transmit line and the bus driver. It guards against a controller that fails and holds its transmit line dominant (low), which would otherwise lock the whole network. A recessive-to-dominant transition on the transmit line starts a timer. If the line does not go recessive again before a programmable number of clock cycles has passed, the block withdraws the driver enable, which leaves the bus recessive. It also raises a fault flag.

The transmit input is asynchronous and passes through a synchronizer inside the block. The driver stays disabled, and the flag stays set, for as long as the line stays dominant. Both are released only once the line has been seen recessive again. Timing is active only in normal mode, and standby mode always withdraws the driver enable. After reset the driver stays off until the transmit line has been seen recessive at least once. Because of this, a line stuck low from power-up can never drive the bus.

Top module: `txd_dom_timeout`

## Requirements
- R1: After reset, `drv_en` and `tmo_fault` are 0. `drv_en` stays 0 while `txd_in` is held low. After `txd_in` goes high it becomes 1 at the third rising clock edge.
- R2: In normal mode (`mode_stby`=0) with the driver enabled, a high-to-low change of `txd_in` that persists makes `tmo_fault` 1 and `drv_en` 0 at rising edge `tmo_cycles`+3 after the change, and not earlier.
- R3: A low pulse on `txd_in` lasting at most `tmo_cycles`-2 clock cycles causes no fault, and `drv_en` is 1 again once the line is high.
- R4: Once set, `tmo_fault` stays 1 and `drv_en` stays 0 for as long as `txd_in` stays low, however long that is.
- R5: After a fault, `txd_in` going high clears `tmo_fault` and restores `drv_en` at the third rising edge.
- R6: With `mode_stby`=1, `drv_en` is 0 in the same cycle, no timing takes place, and holding `txd_in` low raises no fault.
- R7: The timer is started only by a high-to-low change seen in normal mode. Entering normal mode while `txd_in` is already low leaves `drv_en` at 1 with no fault, however long the line stays low.
- R8: The cycle counter saturates instead of wrapping. The largest `tmo_cycles` value (all ones) still gives a fault at edge `tmo_cycles`+3.
- R9: `drv_en` and `tmo_fault` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txd_in | input | 1 | Transmit data from the controller, asynchronous, low = dominant |
| mode_stby | input | 1 | 1 = standby, 0 = normal mode |
| tmo_cycles | input | CNT_W | Timeout length in clock cycles |
| drv_en | output | 1 | Bus driver enable |
| tmo_fault | output | 1 | Driver withdrawn by the dominant timeout |

## Verification
Two synchronizer flops delay every effect of `txd_in`. A falling edge arms the timer at the third edge, the fault register is set at edge `tmo_cycles`+3, and a recovery or a first-high release lands at the third edge. `mode_stby` acts on `drv_en` combinationally. Each task drives its inputs just after a rising edge. It then counts edges to the exact edge before and the exact edge of each expected change and samples 1 ns after that edge, so a result that comes one cycle early or late is caught.

// File: rtl/txdto_pkg.sv
package txdto_pkg;

   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_STBY   = 1'b1
   } txdto_mode_e;

   localparam int unsigned TXDTO_MIN_CNT_W = 2;
   localparam int unsigned TXDTO_MAX_CNT_W = 32;
   localparam int unsigned TXDTO_MIN_SYNC  = 2;

   typedef struct packed {
      logic seen_hi;
      logic fault;
   } txdto_latch_t;

endpackage

// File: rtl/txdto_sync.sv
module txdto_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= RST_VAL;
               else        chain[gi] <= d_in;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= RST_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];

endmodule

// File: rtl/txdto_edge.sv
module txdto_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);

   logic lvl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign fall = lvl_d & ~lvl;

endmodule

// File: rtl/txdto_timer.sv
module txdto_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_ok,
   input  logic             lvl,
   input  logic             fall,
   input  logic [CNT_W-1:0] limit,
   output logic             armed,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (!run_ok || lvl) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (fall) begin
         armed <= 1'b1;
         cnt   <= CNT_ONE;
      end else if (armed && (cnt != CNT_MAX)) begin
         cnt   <= cnt + CNT_ONE;
      end
   end

   assign expire = armed && (cnt >= limit);

endmodule

// File: rtl/txdto_latch.sv
module txdto_latch
   import txdto_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lvl,
   input  logic         expire,
   output txdto_latch_t st
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         if (lvl) st.seen_hi <= 1'b1;
         if (lvl)         st.fault <= 1'b0;
         else if (expire) st.fault <= 1'b1;
      end
   end

endmodule

// File: rtl/txd_dom_timeout.sv
module txd_dom_timeout
   import txdto_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txd_in,
   input  logic             mode_stby,
   input  logic [CNT_W-1:0] tmo_cycles,
   output logic             drv_en,
   output logic             tmo_fault
);

   generate
      if (CNT_W < TXDTO_MIN_CNT_W || CNT_W > TXDTO_MAX_CNT_W) begin : g_bad_cnt_w
         $error("txd_dom_timeout: CNT_W out of range");
      end
      if (SYNC_STAGES < TXDTO_MIN_SYNC) begin : g_bad_sync
         $error("txd_dom_timeout: SYNC_STAGES below minimum");
      end
   endgenerate

   logic             txd_s;
   logic             fall;
   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic             expire;
   logic             normal;
   logic             seen_hi;
   txdto_latch_t     st;

   assign normal = (txdto_mode_e'(mode_stby) == MODE_NORMAL);

   txdto_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (txd_in),
      .q_out (txd_s)
   );

   txdto_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (txd_s),
      .fall  (fall)
   );

   txdto_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_ok (normal & seen_hi),
      .lvl    (txd_s),
      .fall   (fall),
      .limit  (tmo_cycles),
      .armed  (armed),
      .cnt    (cnt),
      .expire (expire)
   );

   txdto_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (txd_s),
      .expire (expire),
      .st     (st)
   );

   assign seen_hi   = st.seen_hi;
   assign tmo_fault = st.fault;
   assign drv_en    = seen_hi & ~st.fault & normal;

endmodule

// File: rtl/txdto_chk.sv
module txdto_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_stby,
   input logic             txd_s,
   input logic             armed,
   input logic [CNT_W-1:0] cnt,
   input logic             seen_hi,
   input logic             drv_en,
   input logic             tmo_fault
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   a_r1_no_drive_before_high: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_hi |-> !drv_en);

   a_r2_fault_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_fault) |-> ($past(armed) && !$past(txd_s)));

   a_r4_fault_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_fault && !txd_s) |=> tmo_fault);

   a_r5_fault_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_fault && txd_s) |=> !tmo_fault);

   a_r6_stby_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      mode_stby |-> !drv_en);

   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt == CNT_MAX && !txd_s && !mode_stby) |=> (cnt == CNT_MAX));

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_en && tmo_fault));

endmodule

bind txd_dom_timeout txdto_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_stby (mode_stby),
   .txd_s     (txd_s),
   .armed     (armed),
   .cnt       (cnt),
   .seen_hi   (seen_hi),
   .drv_en    (drv_en),
   .tmo_fault (tmo_fault)
);

// File: tb/test_txd_dom_timeout.sv
`timescale 1ns/1ps
module test_txd_dom_timeout;

   localparam int CNT_W = 16;
   localparam int T     = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             txd_in = 1'b0;
   logic             mode_stby = 1'b0;
   logic [CNT_W-1:0] tmo_cycles = CNT_W'(T);
   logic             drv_en;
   logic             tmo_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   txd_dom_timeout #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_txd_dom_timeout (
      .clk        (clk),
      .rst_n      (rst_n),
      .txd_in     (txd_in),
      .mode_stby  (mode_stby),
      .tmo_cycles (tmo_cycles),
      .drv_en     (drv_en),
      .tmo_fault  (tmo_fault)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic en_exp, input logic f_exp);
      checks++;
      if (drv_en !== en_exp || tmo_fault !== f_exp) begin
         errors++;
         $display("FAIL %s: drv_en=%b tmo_fault=%b expected drv_en=%b tmo_fault=%b",
                  req, drv_en, tmo_fault, en_exp, f_exp);
      end
   endtask

   // R1: reset state and first-high enable
   task automatic t_reset;
      rst_n = 1'b0; txd_in = 1'b0; mode_stby = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 reset", 1'b0, 1'b0);
      step(10);
      chk("R1 low after reset", 1'b0, 1'b0);
      txd_in = 1'b1;
      step(2);
      chk("R1 before third edge", 1'b0, 1'b0);
      step(1);
      chk("R1 enable after high", 1'b1, 1'b0);
   endtask

   // R2, R4, R5, R9: timeout, hold and release
   task automatic t_timeout(input int lim, input string tag);
      tmo_cycles = CNT_W'(lim);
      txd_in = 1'b0;
      step(lim + 2);
      chk({tag, " edge before timeout"}, 1'b1, 1'b0);
      step(1);
      chk({tag, " timeout edge"}, 1'b0, 1'b1);
   endtask

   task automatic t_hold_release;
      step(300);
      chk("R4 fault held while low", 1'b0, 1'b1);
      txd_in = 1'b1;
      step(2);
      chk("R5 before release edge", 1'b0, 1'b1);
      step(1);
      chk("R5 released", 1'b1, 1'b0);
   endtask

   // R3: short dominant pulse
   task automatic t_short;
      tmo_cycles = CNT_W'(T);
      txd_in = 1'b0;
      step(T - 2);
      chk("R3 during short pulse", 1'b1, 1'b0);
      txd_in = 1'b1;
      step(T + 5);
      chk("R3 no fault after short pulse", 1'b1, 1'b0);
   endtask

   // R6, R7: standby and arming rule
   task automatic t_standby;
      txd_in = 1'b1;
      step(3);
      mode_stby = 1'b1;
      #1;
      chk("R6 standby same cycle", 1'b0, 1'b0);
      txd_in = 1'b0;
      step(T + 10);
      chk("R6 no fault in standby", 1'b0, 1'b0);
      mode_stby = 1'b0;
      #1;
      chk("R7 normal with line low", 1'b1, 1'b0);
      step(T + 20);
      chk("R7 no arming without edge", 1'b1, 1'b0);
      txd_in = 1'b1;
      step(3);
      chk("R7 line high", 1'b1, 1'b0);
   endtask

   initial begin
      t_reset();
      t_timeout(T, "R2");
      t_hold_release();
      t_short();
      t_standby();
      t_timeout(T, "R2 after standby");
      t_hold_release();
      t_timeout(3, "R2 short limit");
      t_hold_release();
      t_timeout((1 << CNT_W) - 1, "R8 max limit");
      step(50);
      chk("R8 saturated fault held", 1'b0, 1'b1);
      t_hold_release();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule